// File: doc/BRIEF.md
# Multiplexed GPIO Port Controller

This block is a general-purpose I/O port of parameterised width, driven through a simple word-addressed register bus. Each pin is either under software control or handed to one of three peripheral functions. A 2-bit function code per pin makes the choice. In software mode the pin drive comes from an output latch and the drive enable comes from a direction bit. In peripheral mode the chosen peripheral supplies both the drive value and the drive enable.

Every pin input passes through a two-stage synchroniser. The synchronised level is what software reads at the data address, and it is also what reaches the input of the selected peripheral. Peripheral inputs that are not selected are held at 0. The output latch can be loaded whole through the data address, or changed bit by bit through three write-only aliases that set, clear or invert the bits written as 1. Because the bus carries one access per cycle, every change to the latch is atomic.

Top module: `gpio_mux`

## Requirements
- R1: After reset, every pin has function code 00 and direction 0, the output latch is 0, `pin_oe_o` is 0, and every peripheral input bit is 0.
- R2: With function code 00 (software mode), `pin_o` equals the output latch bit and `pin_oe_o` equals the direction bit, where 1 means drive and 0 means high impedance.
- R3: With function code 01, 10 or 11, `pin_o` and `pin_oe_o` are taken from peripheral index 0, 1 or 2 respectively (`per_do_i[k]`, `per_oe_i[k]`).
- R4: `per_di_o[k][p]` carries the synchronised level of pin p only when pin p's code is k+1. In every other case it is 0, and in software mode all three are 0.
- R5: A read at word address 0 returns in the low NUM_PINS bits the pin level sampled two clock edges earlier. The upper bits are 0.
- R6: A write at address 0 loads the output latch from `wdata_i[NUM_PINS-1:0]` at the next clock edge.
- R7: A write at address 1 sets to 1 the latch bits whose `wdata_i` bit is 1. All other latch bits are unchanged.
- R8: A write at address 2 clears to 0 the latch bits whose `wdata_i` bit is 1. All other latch bits are unchanged.
- R9: A write at address 3 inverts the latch bits whose `wdata_i` bit is 1. All other latch bits are unchanged.
- R10: Reads at addresses 1, 2 and 3 return 0. Address 4 reads back the direction register. Address 5+j reads back the function codes, with pin p at bits [2*(p mod DW/2)+1 : 2*(p mod DW/2)] of j = p div (DW/2). Unmapped addresses read 0, and writes to them change nothing.
- R11: `rdata_o` is 0 in any cycle without a read (`req_i` low, or `we_i` high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | AW | Word address |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data, same cycle as the request |
| pin_i | input | NUM_PINS | Pad input levels |
| pin_o | output | NUM_PINS | Pad output values |
| pin_oe_o | output | NUM_PINS | Pad output enables |
| per_do_i | input | 3 x NUM_PINS | Peripheral output values |
| per_oe_i | input | 3 x NUM_PINS | Peripheral output enables |
| per_di_o | output | 3 x NUM_PINS | Routed peripheral inputs |

## Verification
The assertions assume that at most one register access arrives per cycle and that addresses stay inside AW bits. The synchroniser check also assumes that the cycle counter it keeps starts from a clean reset release. The stimulus changes the pins, the peripheral signals and the bus only on the falling clock edge, so every rising edge samples settled values. Only one operation is issued per cycle. Random traffic is mixed with directed phases that sweep every function code and cover the unmapped addresses 6 and 7.

// File: rtl/gpio_mux_pkg.sv
package gpio_mux_pkg;
  localparam int NUM_PER = 3;

  typedef enum logic [1:0] {
    FN_SW   = 2'b00,
    FN_PER0 = 2'b01,
    FN_PER1 = 2'b10,
    FN_PER2 = 2'b11
  } fn_sel_e;

  localparam int A_DATA  = 0;
  localparam int A_SET   = 1;
  localparam int A_CLR   = 2;
  localparam int A_TGL   = 3;
  localparam int A_DIR   = 4;
  localparam int A_FSEL0 = 5;
endpackage

// File: rtl/gpio_mux_sync.sv
module gpio_mux_sync #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/gpio_mux_regs.sv
module gpio_mux_regs
  import gpio_mux_pkg::*;
#(
  parameter int NUM_PINS = 16,
  parameter int DW       = 32,
  parameter int AW       = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_i,
  input  logic                     we_i,
  input  logic [AW-1:0]            addr_i,
  input  logic [DW-1:0]            wdata_i,
  output logic [DW-1:0]            rdata_o,
  input  logic [NUM_PINS-1:0]      pin_sync_i,
  output logic [NUM_PINS-1:0]      lat_o,
  output logic [NUM_PINS-1:0]      dir_o,
  output logic [NUM_PINS-1:0][1:0] fsel_o
);
  localparam int FPR = DW / 2;

  logic [NUM_PINS-1:0]      lat_q, dir_q, wmask;
  logic [NUM_PINS-1:0][1:0] fsel_q;
  logic                     wr, rd;

  assign wr    = req_i & we_i;
  assign rd    = req_i & ~we_i;
  assign wmask = wdata_i[NUM_PINS-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q <= '0;
    end else if (wr) begin
      case (int'(addr_i))
        A_DATA:  lat_q <= wmask;
        A_SET:   lat_q <= lat_q | wmask;
        A_CLR:   lat_q <= lat_q & ~wmask;
        A_TGL:   lat_q <= lat_q ^ wmask;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= '0;
    end else if (wr && int'(addr_i) == A_DIR) begin
      dir_q <= wmask;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fsel_q <= '0;
    end else if (wr) begin
      for (int p = 0; p < NUM_PINS; p++) begin
        if (int'(addr_i) == A_FSEL0 + p / FPR)
          fsel_q[p] <= wdata_i[2*(p%FPR) +: 2];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd) begin
      case (int'(addr_i))
        A_DATA:  rdata_o = DW'(pin_sync_i);
        A_DIR:   rdata_o = DW'(dir_q);
        default: begin
          for (int p = 0; p < NUM_PINS; p++) begin
            if (int'(addr_i) == A_FSEL0 + p / FPR)
              rdata_o[2*(p%FPR) +: 2] = fsel_q[p];
          end
        end
      endcase
    end
  end

  assign lat_o  = lat_q;
  assign dir_o  = dir_q;
  assign fsel_o = fsel_q;
endmodule

// File: rtl/gpio_mux_pin.sv
module gpio_mux_pin
  import gpio_mux_pkg::*;
(
  input  logic [1:0]         fsel_i,
  input  logic               lat_i,
  input  logic               dir_i,
  input  logic               sync_i,
  input  logic [NUM_PER-1:0] per_do_i,
  input  logic [NUM_PER-1:0] per_oe_i,
  output logic               pin_o,
  output logic               pin_oe_o,
  output logic [NUM_PER-1:0] per_di_o
);
  always_comb begin
    unique case (fn_sel_e'(fsel_i))
      FN_PER0: begin pin_o = per_do_i[0]; pin_oe_o = per_oe_i[0]; end
      FN_PER1: begin pin_o = per_do_i[1]; pin_oe_o = per_oe_i[1]; end
      FN_PER2: begin pin_o = per_do_i[2]; pin_oe_o = per_oe_i[2]; end
      default: begin pin_o = lat_i;       pin_oe_o = dir_i;       end
    endcase
  end

  for (genvar k = 0; k < NUM_PER; k++) begin : g_route
    assign per_di_o[k] = (fsel_i == 2'(k + 1)) & sync_i;
  end
endmodule

// File: rtl/gpio_mux.sv
module gpio_mux
  import gpio_mux_pkg::*;
#(
  parameter int NUM_PINS = 16,
  parameter int DW       = 32,
  parameter int AW       = 4
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              req_i,
  input  logic                              we_i,
  input  logic [AW-1:0]                     addr_i,
  input  logic [DW-1:0]                     wdata_i,
  output logic [DW-1:0]                     rdata_o,
  input  logic [NUM_PINS-1:0]               pin_i,
  output logic [NUM_PINS-1:0]               pin_o,
  output logic [NUM_PINS-1:0]               pin_oe_o,
  input  logic [NUM_PER-1:0][NUM_PINS-1:0]  per_do_i,
  input  logic [NUM_PER-1:0][NUM_PINS-1:0]  per_oe_i,
  output logic [NUM_PER-1:0][NUM_PINS-1:0]  per_di_o
);
  logic [NUM_PINS-1:0]      pin_sync, lat_q, dir_q;
  logic [NUM_PINS-1:0][1:0] fsel_q;

  gpio_mux_sync #(.W(NUM_PINS)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_sync)
  );

  gpio_mux_regs #(.NUM_PINS(NUM_PINS), .DW(DW), .AW(AW)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .we_i      (we_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .rdata_o   (rdata_o),
    .pin_sync_i(pin_sync),
    .lat_o     (lat_q),
    .dir_o     (dir_q),
    .fsel_o    (fsel_q)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic [NUM_PER-1:0] do_p, oe_p, di_p;
    for (genvar k = 0; k < NUM_PER; k++) begin : g_per
      assign do_p[k]        = per_do_i[k][p];
      assign oe_p[k]        = per_oe_i[k][p];
      assign per_di_o[k][p] = di_p[k];
    end
    gpio_mux_pin u_pin (
      .fsel_i  (fsel_q[p]),
      .lat_i   (lat_q[p]),
      .dir_i   (dir_q[p]),
      .sync_i  (pin_sync[p]),
      .per_do_i(do_p),
      .per_oe_i(oe_p),
      .pin_o   (pin_o[p]),
      .pin_oe_o(pin_oe_o[p]),
      .per_di_o(di_p)
    );
  end
endmodule

// File: rtl/gpio_mux_chk.sv
module gpio_mux_chk
  import gpio_mux_pkg::*;
#(
  parameter int NUM_PINS = 16,
  parameter int DW       = 32,
  parameter int AW       = 4
) (
  input logic                             clk_i,
  input logic                             rst_ni,
  input logic                             req_i,
  input logic                             we_i,
  input logic [AW-1:0]                    addr_i,
  input logic [DW-1:0]                    wdata_i,
  input logic [DW-1:0]                    rdata_o,
  input logic [NUM_PINS-1:0]              pin_i,
  input logic [NUM_PINS-1:0]              pin_o,
  input logic [NUM_PINS-1:0]              pin_oe_o,
  input logic [NUM_PER-1:0][NUM_PINS-1:0] per_do_i,
  input logic [NUM_PER-1:0][NUM_PINS-1:0] per_oe_i,
  input logic [NUM_PER-1:0][NUM_PINS-1:0] per_di_o,
  input logic [NUM_PINS-1:0]              lat,
  input logic [NUM_PINS-1:0]              dir,
  input logic [NUM_PINS-1:0][1:0]         fsel
);
  logic [1:0] cyc_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cyc_q <= '0;
    else if (cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
  end

  logic wr, rd;
  assign wr = req_i & we_i;
  assign rd = req_i & ~we_i;

  a_r6_data_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && int'(addr_i) == A_DATA) |=> lat == $past(wdata_i[NUM_PINS-1:0]));

  a_r7_set_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && int'(addr_i) == A_SET) |=>
      lat == ($past(lat) | $past(wdata_i[NUM_PINS-1:0])));

  a_r8_clr_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && int'(addr_i) == A_CLR) |=>
      lat == ($past(lat) & ~$past(wdata_i[NUM_PINS-1:0])));

  a_r9_tgl_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && int'(addr_i) == A_TGL) |=>
      lat == ($past(lat) ^ $past(wdata_i[NUM_PINS-1:0])));

  a_r10_wo_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && (int'(addr_i) == A_SET || int'(addr_i) == A_CLR || int'(addr_i) == A_TGL))
      |-> rdata_o == '0);

  a_r11_idle_rdata: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd |-> rdata_o == '0);

  a_r5_sync_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 2'd2 && rd && int'(addr_i) == A_DATA)
      |-> rdata_o[NUM_PINS-1:0] == $past(pin_i, 2));

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pchk
    a_r2_sw_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fsel[p] == 2'b00) |-> (pin_o[p] == lat[p] && pin_oe_o[p] == dir[p]));

    a_r3_per_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fsel[p] != 2'b00) |->
        (pin_o[p] == per_do_i[fsel[p] - 2'd1][p] &&
         pin_oe_o[p] == per_oe_i[fsel[p] - 2'd1][p]));

    a_r4_route_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({per_di_o[2][p], per_di_o[1][p], per_di_o[0][p]}));

    a_r4_sw_no_route: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fsel[p] == 2'b00) |->
        {per_di_o[2][p], per_di_o[1][p], per_di_o[0][p]} == 3'b000);
  end
endmodule

bind gpio_mux gpio_mux_chk #(.NUM_PINS(NUM_PINS), .DW(DW), .AW(AW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .pin_i   (pin_i),
  .pin_o   (pin_o),
  .pin_oe_o(pin_oe_o),
  .per_do_i(per_do_i),
  .per_oe_i(per_oe_i),
  .per_di_o(per_di_o),
  .lat     (lat_q),
  .dir     (dir_q),
  .fsel    (fsel_q)
);

// File: tb/gpio_mux_bench.sv
module gpio_mux_bench;
  localparam int NP = 16;
  localparam int DW = 32;
  localparam int AW = 4;

  logic                 clk_i = 1'b0;
  logic                 rst_ni = 1'b0;
  logic                 req_i = 1'b0, we_i = 1'b0;
  logic [AW-1:0]        addr_i = '0;
  logic [DW-1:0]        wdata_i = '0;
  logic [DW-1:0]        rdata_o;
  logic [NP-1:0]        pin_i = '0, pin_o, pin_oe_o;
  logic [2:0][NP-1:0]   per_do_i = '0, per_oe_i = '0, per_di_o;

  gpio_mux #(.NUM_PINS(NP), .DW(DW), .AW(AW)) u_gpio_mux (.*);

  always #5 clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // reference state
  logic [NP-1:0] m_lat = '0, m_dir = '0;
  logic [1:0]    m_fsel [NP];
  logic [NP-1:0] hist [$];

  task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [NP-1:0] sync_exp();
    return (hist.size() >= 2) ? hist[1] : '0;
  endfunction

  task automatic compare(string wtag);
    logic [NP-1:0] gm, eo, eoe;
    logic [2:0][NP-1:0] edi;
    logic [DW-1:0] er;
    gm = '0; eo = '0; eoe = '0; edi = '0;
    for (int p = 0; p < NP; p++) begin
      if (m_fsel[p] == 2'b00) begin
        gm[p] = 1'b1; eo[p] = m_lat[p]; eoe[p] = m_dir[p];
      end else begin
        eo[p]  = per_do_i[m_fsel[p]-1][p];
        eoe[p] = per_oe_i[m_fsel[p]-1][p];
        edi[m_fsel[p]-1][p] = sync_exp()[p];
      end
    end
    check({wtag, " sw pin_o"}, DW'(pin_o & gm), DW'(eo & gm));
    check("R2 sw pin_oe", DW'(pin_oe_o & gm), DW'(eoe & gm));
    check("R3 per pin_o", DW'(pin_o & ~gm), DW'(eo & ~gm));
    check("R3 per pin_oe", DW'(pin_oe_o & ~gm), DW'(eoe & ~gm));
    check("R4 per_di", DW'(per_di_o), DW'(edi));
    er = '0;
    if (req_i && !we_i) begin
      case (int'(addr_i))
        0: er = DW'(sync_exp());
        4: er = DW'(m_dir);
        5: for (int p = 0; p < NP; p++) er[2*p +: 2] = m_fsel[p];
        default: er = '0;
      endcase
      check(int'(addr_i) == 0 ? "R5 data read" : "R10 readback", rdata_o, er);
    end else begin
      check("R11 idle rdata", rdata_o, '0);
    end
  endtask

  string last_tag = "R2";

  // one bus cycle; inputs driven at negedge
  task automatic step(bit rq, bit w, int a, logic [DW-1:0] d);
    logic [NP-1:0] m;
    req_i = rq; we_i = w; addr_i = AW'(a); wdata_i = d;
    pin_i = NP'($urandom); per_do_i = 48'({$urandom, $urandom}); per_oe_i = 48'({$urandom, $urandom});
    #1 compare(last_tag);
    @(posedge clk_i);
    hist.push_front(pin_i);
    if (hist.size() > 3) void'(hist.pop_back());
    m = d[NP-1:0];
    last_tag = "R2";
    if (rq && w) begin
      case (a)
        0: begin m_lat = m;           last_tag = "R6"; end
        1: begin m_lat = m_lat | m;   last_tag = "R7"; end
        2: begin m_lat = m_lat & ~m;  last_tag = "R8"; end
        3: begin m_lat = m_lat ^ m;   last_tag = "R9"; end
        4: m_dir = m;
        5: for (int p = 0; p < NP; p++) m_fsel[p] = d[2*p +: 2];
        default: ;
      endcase
    end
    @(negedge clk_i);
  endtask

  initial begin
    for (int p = 0; p < NP; p++) m_fsel[p] = 2'b00;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    req_i = 1'b1; addr_i = AW'(4);
    #1;
    check("R1 dir reset", rdata_o, '0);
    check("R1 oe reset", DW'(pin_oe_o), '0);
    check("R1 pin_o reset", DW'(pin_o), '0);
    check("R1 per_di reset", DW'(per_di_o), '0);
    addr_i = AW'(5);
    #1 check("R1 fsel reset", rdata_o, '0);
    @(negedge clk_i);
    // software mode, all outputs
    step(1, 1, 4, 32'h0000_ffff);
    step(1, 1, 0, 32'h0000_a5a5);
    step(0, 0, 0, 0);
    step(1, 1, 1, 32'h0000_0f0f);
    step(0, 0, 0, 0);
    step(1, 1, 2, 32'h0000_3c3c);
    step(0, 0, 0, 0);
    step(1, 1, 3, 32'h0000_ffff);
    step(0, 0, 0, 0);
    step(1, 0, 1, 0);
    step(1, 0, 2, 0);
    step(1, 0, 3, 0);
    step(1, 0, 4, 0);
    // unmapped addresses
    step(1, 1, 6, 32'hffff_ffff);
    step(1, 1, 7, 32'hffff_ffff);
    step(1, 0, 6, 0);
    step(1, 0, 7, 0);
    // sweep every function code
    step(1, 1, 5, 32'h5555_5555);
    for (int i = 0; i < 4; i++) step(1, 0, 0, 0);
    step(1, 1, 5, 32'haaaa_aaaa);
    for (int i = 0; i < 4; i++) step(1, 0, 0, 0);
    step(1, 1, 5, 32'hffff_ffff);
    for (int i = 0; i < 4; i++) step(1, 0, 5, 0);
    step(1, 1, 5, 32'he4e4_1b1b);
    step(1, 0, 5, 0);
    // random traffic
    for (int i = 0; i < 1500; i++)
      step(1'($urandom), 1'($urandom), int'($urandom_range(0, 7)), $urandom);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule